// File: doc/BRIEF.md
# Memory Fill Self-Test Controller

This block is a self-test engine for a byte-wide buffer memory of 2^ADDR_W locations (8 Kbytes by default). A host starts a run through four 8-bit registers on a small address/data bus. The engine then writes a generated byte to every location in ascending order. Next it reads the whole buffer back and folds the contents into a 16-bit ones'-complement checksum. The checksum can be read as two bytes. A status bit shows whether a run is in progress, and hardware clears it when the run ends.

Three data sources can be chosen: an 8-bit maximal-length LFSR started from the seed register, the low byte of each address, or the seed byte rotated left by a programmable amount after every write. The memory has two synchronous ports. A DMA client and the engine share them through a swap control. The usual assignment puts the DMA client on port A and the engine on port B, and the swap control reverses it.

Top module: `mbist_top`

## Requirements
- R1: After reset, all four registers read 0x00. Register select 0 is control, 1 is seed, 2 is checksum high byte, and 3 is checksum low byte.
- R2: The control byte holds rotate amount in bits 7:5, port swap in bit 4, fill mode in bits 3:2, enable in bit 1 and start/busy in bit 0. Writing a control byte with bits 1 and 0 both set starts a run. Bit 0 then reads 1 until the fill and read-back passes are done, and hardware clears it.
- R3: A control write with the enable bit at 0, or with fill mode 11, starts nothing. No memory access takes place and bit 0 reads 0.
- R4: A run writes each address from 0 up to 2^ADDR_W-1 exactly once, in ascending order, one address per clock.
- R5: Fill mode 00 writes LFSR data. The first byte is the seed, or 0x01 if the seed is zero. Each following byte is {p[6:0], p[7]^p[5]^p[4]^p[3]}, where p is the previous byte.
- R6: Fill mode 01 writes the low 8 bits of the address to each location. The rotate amount has no effect.
- R7: Fill mode 10 writes the seed to location 0. Each following byte is the previous byte rotated left by the amount in control bits 7:5. The rotate amount is ignored in modes 00 and 01.
- R8: The checksum starts at 0. It is the 16-bit ones'-complement sum (end-around carry) of words made from each even address (high byte) and the next odd address (low byte). It is final when bit 0 reads 0. Writes to selects 2 and 3 are ignored.
- R9: With swap at 0, the DMA client uses port A and the engine uses port B. With swap at 1, the two are reversed. DMA read data returns from the DMA client's port one clock after the request.
- R10: Writes to the control and seed registers are ignored while a run is in progress.
- R11: While idle, the engine makes no access on its memory port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dma_en | input | 1 | DMA client access request |
| dma_we | input | 1 | DMA client write |
| dma_addr | input | ADDR_W | DMA client address |
| dma_wdata | input | 8 | DMA client write data |
| dma_rdata | output | 8 | DMA client read data |
| ram_a_en | output | 1 | Port A enable |
| ram_a_we | output | 1 | Port A write |
| ram_a_addr | output | ADDR_W | Port A address |
| ram_a_wdata | output | 8 | Port A write data |
| ram_a_rdata | input | 8 | Port A read data, one clock after the request |
| ram_b_en | output | 1 | Port B enable |
| ram_b_we | output | 1 | Port B write |
| ram_b_addr | output | ADDR_W | Port B address |
| ram_b_wdata | output | 8 | Port B write data |
| ram_b_rdata | input | 8 | Port B read data, one clock after the request |

## Verification
The assertions assume that the attached memory returns read data exactly one clock after an enabled read, and that nothing except the selected client drives each port. They also assume that reset is applied before the first run. The bench models a two-port RAM with that single-clock latency and keeps the DMA client idle while a run is in progress. It drives the DMA client only while the engine is idle. Each run uses a seed, mode, rotate amount and swap setting drawn from a fixed-seed generator or chosen by hand, and the expected buffer image and checksum are rebuilt in the bench.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  localparam int BYTE_W = 8;
  localparam int CKS_W  = 16;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_SEED = 2'd1;
  localparam logic [1:0] SEL_CKH  = 2'd2;
  localparam logic [1:0] SEL_CKL  = 2'd3;

  typedef enum logic [1:0] {
    MODE_RAND  = 2'b00,
    MODE_ADDR  = 2'b01,
    MODE_SHIFT = 2'b10,
    MODE_RSVD  = 2'b11
  } fill_mode_e;

  typedef struct packed {
    logic [2:0] rot;
    logic       swap;
    fill_mode_e mode;
    logic       enable;
    logic       go;
  } ctrl_t;

  function automatic logic [BYTE_W-1:0] lfsr_next(input logic [BYTE_W-1:0] p);
    return {p[6:0], p[7] ^ p[5] ^ p[4] ^ p[3]};
  endfunction

  function automatic logic [BYTE_W-1:0] rotl8(input logic [BYTE_W-1:0] p,
                                              input logic [2:0] n);
    logic [2*BYTE_W-1:0] w;
    w = {p, p} << n;
    return w[2*BYTE_W-1:BYTE_W];
  endfunction

  function automatic logic [CKS_W-1:0] oc_add(input logic [CKS_W-1:0] a,
                                              input logic [CKS_W-1:0] b);
    logic [CKS_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CKS_W-1:0] + {{(CKS_W-1){1'b0}}, s[CKS_W]};
  endfunction

endpackage

// File: rtl/mbist_regs.sv
module mbist_regs
  import mbist_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_we,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              busy,
  input  logic [CKS_W-1:0]  cks,
  output logic [BYTE_W-1:0] reg_rdata,
  output ctrl_t             cfg,
  output logic [BYTE_W-1:0] seed,
  output logic              start
);

  ctrl_t             ctrl_q, ctrl_d;
  logic [BYTE_W-1:0] seed_q, seed_d;
  logic              ctrl_en, seed_en, wr_ok;

  // next-state
  always_comb begin
    wr_ok   = reg_we && !busy;
    ctrl_en = wr_ok && (reg_sel == SEL_CTRL);
    seed_en = wr_ok && (reg_sel == SEL_SEED);
    ctrl_d  = ctrl_t'({reg_wdata[BYTE_W-1:1], 1'b0});
    seed_d  = reg_wdata;
    start   = ctrl_en && reg_wdata[1] && reg_wdata[0] &&
              (reg_wdata[3:2] != MODE_RSVD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      seed_q <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (seed_en) seed_q <= seed_d;
    end
  end

  // read mux
  always_comb begin
    case (reg_sel)
      SEL_CTRL: reg_rdata = {ctrl_q.rot, ctrl_q.swap, ctrl_q.mode, ctrl_q.enable, busy};
      SEL_SEED: reg_rdata = seed_q;
      SEL_CKH:  reg_rdata = cks[CKS_W-1:BYTE_W];
      default:  reg_rdata = cks[BYTE_W-1:0];
    endcase
  end

  assign cfg  = ctrl_q;
  assign seed = seed_q;

endmodule

// File: rtl/mbist_patgen.sv
module mbist_patgen
  import mbist_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  fill_mode_e        mode,
  input  logic [2:0]        rot,
  input  logic [BYTE_W-1:0] seed,
  input  logic [BYTE_W-1:0] addr_lo,
  output logic [BYTE_W-1:0] data
);

  logic [BYTE_W-1:0] pat_q, pat_d;
  logic              pat_en;

  always_comb begin
    pat_en = load || adv;
    if (load) begin
      pat_d = ((mode == MODE_RAND) && (seed == '0)) ? 8'h01 : seed;
    end else begin
      case (mode)
        MODE_RAND:  pat_d = lfsr_next(pat_q);
        MODE_SHIFT: pat_d = rotl8(pat_q, rot);
        default:    pat_d = pat_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pat_q <= '0;
    else if (pat_en) pat_q <= pat_d;
  end

  assign data = (mode == MODE_ADDR) ? addr_lo : pat_q;

endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] rdata,
  output logic              busy,
  output logic              load,
  output logic              adv,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CKS_W-1:0]  cks
);

  localparam logic [ADDR_W-1:0] LAST = '1;

  typedef enum logic [2:0] {S_IDLE, S_PREP, S_FILL, S_READ, S_TAIL} st_e;

  st_e               st_q, st_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;
  logic              rv_q, rv_d, rodd_q, rodd_d;
  logic [BYTE_W-1:0] hi_q;
  logic              hi_en;
  logic [CKS_W-1:0]  cks_q, cks_d;
  logic              cks_en;

  // next-state
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    load   = 1'b0;
    adv    = 1'b0;
    mem_en = 1'b0;
    mem_we = 1'b0;
    rv_d   = 1'b0;
    rodd_d = rodd_q;
    case (st_q)
      S_IDLE: if (start) st_d = S_PREP;
      S_PREP: begin
        load   = 1'b1;
        cnt_en = 1'b1;
        cnt_d  = '0;
        st_d   = S_FILL;
      end
      S_FILL: begin
        mem_en = 1'b1;
        mem_we = 1'b1;
        adv    = 1'b1;
        cnt_en = 1'b1;
        if (cnt_q == LAST) begin
          cnt_d = '0;
          st_d  = S_READ;
        end else begin
          cnt_d = cnt_q + ADDR_W'(1);
        end
      end
      S_READ: begin
        mem_en = 1'b1;
        rv_d   = 1'b1;
        rodd_d = cnt_q[0];
        cnt_en = 1'b1;
        if (cnt_q == LAST) begin
          cnt_d = '0;
          st_d  = S_TAIL;
        end else begin
          cnt_d = cnt_q + ADDR_W'(1);
        end
      end
      S_TAIL:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // checksum fold
  always_comb begin
    hi_en  = rv_q && !rodd_q;
    cks_en = (st_q == S_PREP) || (rv_q && rodd_q);
    cks_d  = (st_q == S_PREP) ? '0 : oc_add(cks_q, {hi_q, rdata});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      rv_q   <= 1'b0;
      rodd_q <= 1'b0;
      hi_q   <= '0;
      cks_q  <= '0;
    end else begin
      st_q   <= st_d;
      rv_q   <= rv_d;
      rodd_q <= rodd_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (hi_en)  hi_q  <= rdata;
      if (cks_en) cks_q <= cks_d;
    end
  end

  assign busy     = (st_q != S_IDLE);
  assign mem_addr = cnt_q;
  assign cks      = cks_q;

endmodule

// File: rtl/mbist_portmux.sv
module mbist_portmux
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              swap,
  input  logic              dma_en,
  input  logic              dma_we,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [BYTE_W-1:0] dma_wdata,
  output logic [BYTE_W-1:0] dma_rdata,
  input  logic              eng_en,
  input  logic              eng_we,
  input  logic [ADDR_W-1:0] eng_addr,
  input  logic [BYTE_W-1:0] eng_wdata,
  output logic [BYTE_W-1:0] eng_rdata,
  output logic              a_en,
  output logic              a_we,
  output logic [ADDR_W-1:0] a_addr,
  output logic [BYTE_W-1:0] a_wdata,
  input  logic [BYTE_W-1:0] a_rdata,
  output logic              b_en,
  output logic              b_we,
  output logic [ADDR_W-1:0] b_addr,
  output logic [BYTE_W-1:0] b_wdata,
  input  logic [BYTE_W-1:0] b_rdata
);

  always_comb begin
    if (swap) begin
      a_en = eng_en;  a_we = eng_we;  a_addr = eng_addr;  a_wdata = eng_wdata;
      b_en = dma_en;  b_we = dma_we;  b_addr = dma_addr;  b_wdata = dma_wdata;
      dma_rdata = b_rdata;
      eng_rdata = a_rdata;
    end else begin
      a_en = dma_en;  a_we = dma_we;  a_addr = dma_addr;  a_wdata = dma_wdata;
      b_en = eng_en;  b_we = eng_we;  b_addr = eng_addr;  b_wdata = eng_wdata;
      dma_rdata = a_rdata;
      eng_rdata = b_rdata;
    end
  end

endmodule

// File: rtl/mbist_top.sv
module mbist_top
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              dma_en,
  input  logic              dma_we,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [7:0]        dma_wdata,
  output logic [7:0]        dma_rdata,
  output logic              ram_a_en,
  output logic              ram_a_we,
  output logic [ADDR_W-1:0] ram_a_addr,
  output logic [7:0]        ram_a_wdata,
  input  logic [7:0]        ram_a_rdata,
  output logic              ram_b_en,
  output logic              ram_b_we,
  output logic [ADDR_W-1:0] ram_b_addr,
  output logic [7:0]        ram_b_wdata,
  input  logic [7:0]        ram_b_rdata
);

  logic [1:0]        rs_q;
  logic              rst_sync_n;
  ctrl_t             cfg;
  logic [BYTE_W-1:0] seed;
  logic              start, busy, load, adv;
  logic [CKS_W-1:0]  cks;
  logic              eng_en, eng_we;
  logic [ADDR_W-1:0] eng_addr;
  logic [BYTE_W-1:0] eng_wdata, eng_rdata;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  mbist_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_sel   (reg_sel),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .cks       (cks),
    .reg_rdata (reg_rdata),
    .cfg       (cfg),
    .seed      (seed),
    .start     (start)
  );

  mbist_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .rdata    (eng_rdata),
    .busy     (busy),
    .load     (load),
    .adv      (adv),
    .mem_en   (eng_en),
    .mem_we   (eng_we),
    .mem_addr (eng_addr),
    .cks      (cks)
  );

  mbist_patgen u_pat (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (load),
    .adv     (adv),
    .mode    (cfg.mode),
    .rot     (cfg.rot),
    .seed    (seed),
    .addr_lo (eng_addr[BYTE_W-1:0]),
    .data    (eng_wdata)
  );

  mbist_portmux #(.ADDR_W(ADDR_W)) u_mux (
    .swap      (cfg.swap),
    .dma_en    (dma_en),
    .dma_we    (dma_we),
    .dma_addr  (dma_addr),
    .dma_wdata (dma_wdata),
    .dma_rdata (dma_rdata),
    .eng_en    (eng_en),
    .eng_we    (eng_we),
    .eng_addr  (eng_addr),
    .eng_wdata (eng_wdata),
    .eng_rdata (eng_rdata),
    .a_en      (ram_a_en),
    .a_we      (ram_a_we),
    .a_addr    (ram_a_addr),
    .a_wdata   (ram_a_wdata),
    .a_rdata   (ram_a_rdata),
    .b_en      (ram_b_en),
    .b_we      (ram_b_we),
    .b_addr    (ram_b_addr),
    .b_wdata   (ram_b_wdata),
    .b_rdata   (ram_b_rdata)
  );

endmodule

// File: rtl/mbist_chk.sv
module mbist_chk
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [1:0]        reg_sel,
  input logic [7:0]        reg_wdata,
  input logic              busy,
  input ctrl_t             cfg,
  input logic              eng_we,
  input logic [ADDR_W-1:0] eng_addr,
  input logic [7:0]        eng_wdata,
  input logic [CKS_W-1:0]  cks,
  input logic              ram_a_en,
  input logic              ram_b_en
);

  assert_start_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_we && (reg_sel == SEL_CTRL) && (reg_wdata[1:0] == 2'b11) &&
                          (reg_wdata[3:2] != 2'b11)));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_we && $past(eng_we)) |-> (eng_addr == ADDR_W'($past(eng_addr) + 1'b1)));

  assert_rand_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_we && (cfg.mode == MODE_RAND)) |-> (eng_wdata != 8'h00));

  assert_addr_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_we && (cfg.mode == MODE_ADDR)) |-> (eng_wdata == eng_addr[7:0]));

  assert_shift_rot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_we && $past(eng_we) && (cfg.mode == MODE_SHIFT)) |->
      (eng_wdata == rotl8($past(eng_wdata), cfg.rot)));

  assert_cks_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(cks));

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg));

  assert_idle_b_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cfg.swap) |-> !ram_b_en);

  assert_idle_a_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cfg.swap) |-> !ram_a_en);

endmodule

bind mbist_top mbist_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .busy      (busy),
  .cfg       (cfg),
  .eng_we    (eng_we),
  .eng_addr  (eng_addr),
  .eng_wdata (eng_wdata),
  .cks       (cks),
  .ram_a_en  (ram_a_en),
  .ram_b_en  (ram_b_en)
);

// File: tb/tb_mbist_top.sv
module tb_mbist_top;

  localparam int AW = 10;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    reg_sel = '0;
  logic          reg_we = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          dma_en = 1'b0, dma_we = 1'b0;
  logic [AW-1:0] dma_addr = '0;
  logic [7:0]    dma_wdata = '0;
  logic [7:0]    dma_rdata;
  logic          ram_a_en, ram_a_we, ram_b_en, ram_b_we;
  logic [AW-1:0] ram_a_addr, ram_b_addr;
  logic [7:0]    ram_a_wdata, ram_b_wdata;
  logic [7:0]    ram_a_rdata = '0, ram_b_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit clr_mon = 1'b0;
  int wr_a, wr_b, acc_a, acc_b, ord_a, ord_b;
  logic [AW-1:0] nxt_a, nxt_b;
  logic [7:0] mem  [N];
  logic [7:0] expb [N];
  logic [15:0] last_cks = '0;

  always #10 clk = ~clk;

  mbist_top #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dma_en(dma_en), .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
    .dma_rdata(dma_rdata),
    .ram_a_en(ram_a_en), .ram_a_we(ram_a_we), .ram_a_addr(ram_a_addr),
    .ram_a_wdata(ram_a_wdata), .ram_a_rdata(ram_a_rdata),
    .ram_b_en(ram_b_en), .ram_b_we(ram_b_we), .ram_b_addr(ram_b_addr),
    .ram_b_wdata(ram_b_wdata), .ram_b_rdata(ram_b_rdata)
  );

  // two-port RAM model with one clock of read latency, plus access monitor
  always @(posedge clk) begin
    if (clr_mon) begin
      wr_a = 0; wr_b = 0; acc_a = 0; acc_b = 0; ord_a = 0; ord_b = 0;
      nxt_a = '0; nxt_b = '0;
    end else begin
      if (ram_a_en) begin
        acc_a++;
        if (ram_a_we) begin
          mem[ram_a_addr] <= ram_a_wdata;
          if (ram_a_addr != nxt_a) ord_a++;
          nxt_a = ram_a_addr + 1'b1;
          wr_a++;
        end
        ram_a_rdata <= mem[ram_a_addr];
      end
      if (ram_b_en) begin
        acc_b++;
        if (ram_b_we) begin
          mem[ram_b_addr] <= ram_b_wdata;
          if (ram_b_addr != nxt_b) ord_b++;
          nxt_b = ram_b_addr + 1'b1;
          wr_b++;
        end
        ram_b_rdata <= mem[ram_b_addr];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_we = 1'b0;
    #1 d = reg_rdata;
  endtask

  task automatic clear_mon();
    @(negedge clk); clr_mon = 1'b1;
    @(negedge clk); clr_mon = 1'b0;
  endtask

  function automatic logic [7:0] rot_by(input logic [7:0] p, input int n);
    logic [7:0] r = p;
    for (int i = 0; i < n; i++) r = {r[6:0], r[7]};
    return r;
  endfunction

  function automatic void build_exp(input logic [1:0] mode, input logic [7:0] seed,
                                    input logic [2:0] rot);
    logic [7:0] p;
    p = (mode == 2'b00 && seed == 8'h00) ? 8'h01 : seed;
    for (int a = 0; a < N; a++) begin
      expb[a] = (mode == 2'b01) ? a[7:0] : p;
      if (mode == 2'b00) p = {p[6:0], p[7] ^ p[5] ^ p[4] ^ p[3]};
      else if (mode == 2'b10) p = rot_by(p, int'(rot));
    end
  endfunction

  function automatic logic [15:0] exp_cks();
    int s = 0;
    for (int k = 0; k < N / 2; k++) begin
      s = s + {expb[2*k], expb[2*k+1]};
      if (s > 32'hFFFF) s = s - 32'hFFFF;
    end
    return s[15:0];
  endfunction

  task automatic run_test(input logic [1:0] mode, input logic [7:0] seed,
                          input logic [2:0] rot, input bit swap);
    logic [7:0] cval, v, hi, lo;
    int waited, bad;
    logic [15:0] ec;
    string tag;
    wr(2'd1, seed);
    clear_mon();
    cval = {rot, swap, mode, 2'b11};
    wr(2'd0, cval);
    rd(2'd0, v);
    chk(v[0] == 1'b1, "R2 busy set after start", v, 1);
    wr(2'd0, ~cval);
    wr(2'd1, ~seed);
    rd(2'd0, v);
    chk(v == cval, "R10 control held while busy", v, cval);
    rd(2'd1, v);
    chk(v == seed, "R10 seed held while busy", v, seed);
    waited = 0;
    do begin
      rd(2'd0, v);
      waited++;
    end while (v[0] && waited < 3 * N);
    chk(v == {cval[7:1], 1'b0}, "R2 busy cleared by hardware", v, {cval[7:1], 1'b0});
    build_exp(mode, seed, rot);
    bad = 0;
    for (int i = 0; i < N; i++) if (mem[i] !== expb[i]) bad++;
    tag = (mode == 2'b00) ? "R5 random fill" : (mode == 2'b01) ? "R6 address fill" : "R7 shift fill";
    chk(bad == 0, tag, bad, 0);
    if (swap) begin
      chk(wr_a == N && wr_b == 0, "R9 engine on port A when swapped", wr_a, N);
      chk(ord_a == 0, "R4 ascending single writes", ord_a, 0);
    end else begin
      chk(wr_b == N && wr_a == 0, "R9 engine on port B normally", wr_b, N);
      chk(ord_b == 0, "R4 ascending single writes", ord_b, 0);
    end
    ec = exp_cks();
    rd(2'd2, hi);
    rd(2'd3, lo);
    chk({hi, lo} == ec, "R8 checksum", {hi, lo}, ec);
    last_cks = {hi, lo};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, hi, lo;
    void'($urandom(32'd715));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    for (int s = 0; s < 4; s++) begin
      rd(s[1:0], v);
      chk(v == 8'h00, "R1 reset value", v, 0);
    end

    // R3 start without enable, R3 reserved mode, R11 idle
    clear_mon();
    wr(2'd0, 8'h01);
    repeat (4) @(negedge clk);
    rd(2'd0, v);
    chk(v == 8'h00, "R3 start without enable ignored", v, 0);
    wr(2'd0, 8'h0F);
    repeat (4) @(negedge clk);
    rd(2'd0, v);
    chk(v == 8'h0E, "R3 reserved mode start ignored", v, 8'h0E);
    chk(acc_a + acc_b == 0, "R3 no memory access", acc_a + acc_b, 0);
    chk(acc_b == 0, "R11 idle engine silent", acc_b, 0);

    // directed fills
    run_test(2'b00, 8'h5A, 3'd0, 1'b0);
    run_test(2'b00, 8'h00, 3'd5, 1'b1);
    run_test(2'b01, 8'h33, 3'd2, 1'b0);
    run_test(2'b10, 8'h81, 3'd3, 1'b1);
    run_test(2'b10, 8'hA5, 3'd0, 1'b0);

    // R8 checksum registers are read only
    wr(2'd2, 8'hC3);
    wr(2'd3, 8'h3C);
    rd(2'd2, hi);
    rd(2'd3, lo);
    chk({hi, lo} == last_cks, "R8 checksum write ignored", {hi, lo}, last_cks);

    // constrained random runs
    for (int t = 0; t < 4; t++) begin
      run_test(2'($urandom % 3), 8'($urandom), 3'($urandom), 1'($urandom));
    end

    // R9 DMA access through both port assignments, R11 with engine idle
    wr(2'd0, 8'h00);
    clear_mon();
    @(negedge clk); dma_en = 1'b1; dma_we = 1'b0; dma_addr = 10'd5;
    @(negedge clk); dma_en = 1'b0;
    chk(dma_rdata == mem[5], "R9 DMA read via port A", dma_rdata, mem[5]);
    chk(acc_a == 1 && acc_b == 0, "R11 engine port quiet during DMA", acc_b, 0);
    wr(2'd0, 8'h10);
    clear_mon();
    @(negedge clk); dma_en = 1'b1; dma_we = 1'b1; dma_addr = 10'd7; dma_wdata = 8'hC3;
    @(negedge clk); dma_we = 1'b0; dma_addr = 10'd6;
    @(negedge clk); dma_en = 1'b0;
    chk(wr_b == 1 && wr_a == 0, "R9 DMA write via port B when swapped", wr_b, 1);
    chk(mem[7] == 8'hC3, "R9 DMA write data", mem[7], 8'hC3);
    chk(dma_rdata == mem[6], "R9 DMA read via port B", dma_rdata, mem[6]);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule